// File: doc/BRIEF.md
# Optical Port Transmit Modulator

This block sits between a chip's serial and metering logic and an infrared optical port. A two-bit source field chooses what reaches the optical transmit pin: the serial transmit path, a reactive-energy pulse, an active-energy pulse, or a general I/O bit. When the serial path is chosen and modulation is on, the serial bit gates an infrared carrier made from the system clock. Four duty settings are available. A polarity flip is applied last.

The carrier is built from a step divider on the system clock and a 32-step phase counter. All transmit settings are held in shadow registers. These registers reload only when the phase counter wraps, so a setting change never cuts a carrier pulse short. A bit-bang setting reroutes the paths: general I/O bit 5 takes the place of the serial bit on the optical path, and the serial transmitter moves to the alternate pin, which otherwise carries the second serial output. A receive-disable setting parks the received data at the idle level, which frees the optical receive pin for other use.

Top module: `optx_modulator`

## Requirements
- R1: While reset is asserted, `opt_tx` and `alt_tx` are 0. The shadow settings reset to source 0, modulation off, duty code 0, no inversion and bit-bang off. After reset, `opt_tx` therefore follows `ser_tx` with one cycle of delay.
- R2: The source code picks the optical source: 0 is the serial path, 1 is `pulse_var`, 2 is `pulse_w`, and 3 is `gpio_tx`. The result is registered, so it appears one clock after the sampled inputs.
- R3: With modulation off and source 0, `opt_tx` equals the serial path bit from the previous clock.
- R4: With modulation on and source 0, `opt_tx` is 0 whenever the serial path bit is 1. Whenever the bit is 0, `opt_tx` equals the carrier.
- R5: Carrier high time is 16, 12, 8 or 4 of the 32 phase steps for duty codes 0, 1, 2 and 3 (50%, 37.5%, 25%, 12.5%). The carrier is high on the first steps of each period.
- R6: One phase step lasts DIV = CLK_HZ / (CARRIER_HZ * 32) clocks, so one carrier period lasts 32 * DIV clocks.
- R7: Inversion is applied after source selection and modulation, and it affects all four sources.
- R8: With bit-bang on, `gpio5` replaces `ser_tx` as the serial path bit, and `alt_tx` carries `ser_tx`. With bit-bang off, `alt_tx` carries `ser2_tx`. `alt_tx` is registered with one clock of delay.
- R9: With `cfg_rx_off` set, `opt_rx_data` is held at 1 (idle). With it clear, `opt_rx_data` follows `opt_rx_pin` combinationally.
- R10: All `cfg_*` transmit settings are sampled only on the clock edge that ends phase step 31, which is every 32 * DIV clocks counted from reset release. Until that edge, the previous settings stay in force.
- R11: Modulation has no effect on sources 1 to 3. Those sources pass through unchanged apart from inversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_src | input | 2 | Optical source code |
| cfg_mod_en | input | 1 | Carrier modulation enable |
| cfg_duty | input | 2 | Carrier duty code |
| cfg_invert | input | 1 | Output polarity flip |
| cfg_bitbang | input | 1 | Bit-bang reroute enable |
| cfg_rx_off | input | 1 | Optical receive disable |
| ser_tx | input | 1 | Serial transmitter output |
| ser2_tx | input | 1 | Second serial output for the alternate pin |
| pulse_var | input | 1 | Reactive-energy pulse |
| pulse_w | input | 1 | Active-energy pulse |
| gpio_tx | input | 1 | General I/O bit used as source 3 |
| gpio5 | input | 1 | General I/O bit 5, used in bit-bang mode |
| opt_rx_pin | input | 1 | Optical receive pin |
| opt_tx | output | 1 | Optical transmit pin drive |
| alt_tx | output | 1 | Alternate serial pin drive |
| opt_rx_data | output | 1 | Received data to the serial receiver |

## Verification
A phase counter that drifts or skips shows up as a wrong high time or a wrong pulse count on `opt_tx` within one carrier period. A shadow register that loads too early or too late shows the new source, polarity or duty at the wrong cycle, so the exact cycle of the first change after a mid-period write is checked. Wrong routing in the output stage shows on `opt_tx` or `alt_tx` one clock after the input that exposes it. For this reason, a cycle-exact reference model is compared against both outputs on every clock.

// File: rtl/optx_pkg.sv
package optx_pkg;

  typedef enum logic [1:0] {
    SRC_SERIAL = 2'd0,
    SRC_VAR    = 2'd1,
    SRC_W      = 2'd2,
    SRC_GPIO   = 2'd3
  } src_e;

  typedef struct packed {
    src_e       src;
    logic       mod_en;
    logic [1:0] duty;
    logic       invert;
    logic       bitbang;
  } cfg_t;

  // Carrier high steps in one period: half the period, less one eighth per duty code.
  function automatic int unsigned high_steps(input int unsigned steps, input logic [1:0] duty);
    return steps / 2 - int'(duty) * (steps / 8);
  endfunction

  // Clocks per phase step, never below one.
  function automatic int unsigned step_div(input int unsigned clk_hz, input int unsigned carrier_hz,
                                           input int unsigned steps);
    int unsigned d;
    d = clk_hz / (carrier_hz * steps);
    return (d == 0) ? 1 : d;
  endfunction

endpackage

// File: rtl/optx_carrier.sv
module optx_carrier
  import optx_pkg::*;
#(
  parameter int unsigned CLK_HZ     = 125_000_000,
  parameter int unsigned CARRIER_HZ = 38_000,
  parameter int unsigned STEPS_LOG2 = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            duty,
  output logic [STEPS_LOG2-1:0] phase,
  output logic                  step_tick,
  output logic                  frame_end,
  output logic                  carrier
);
  localparam int unsigned STEPS = 1 << STEPS_LOG2;
  localparam int unsigned DIV   = step_div(CLK_HZ, CARRIER_HZ, STEPS);
  localparam int unsigned CW    = $clog2(DIV + 1);

  logic [CW-1:0]       pre_cnt;
  logic [STEPS_LOG2:0] hi_lim;

  assign step_tick = (pre_cnt == CW'(DIV - 1));
  assign frame_end = step_tick && (phase == '1);
  assign hi_lim    = (STEPS_LOG2 + 1)'(high_steps(STEPS, duty));
  assign carrier   = ({1'b0, phase} < hi_lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      phase   <= '0;
    end else if (step_tick) begin
      pre_cnt <= '0;
      phase   <= phase + 1'b1;
    end else begin
      pre_cnt <= pre_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/optx_cfg_shadow.sv
module optx_cfg_shadow
  import optx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  cfg_t cfg_in,
  output cfg_t cfg_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cfg_q <= '0;
    else if (load) cfg_q <= cfg_in;
  end
endmodule

// File: rtl/optx_route.sv
module optx_route
  import optx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  cfg_t cfg,
  input  logic carrier,
  input  logic ser_tx,
  input  logic ser2_tx,
  input  logic pulse_var,
  input  logic pulse_w,
  input  logic gpio_tx,
  input  logic gpio5,
  output logic path_bit,
  output logic opt_tx,
  output logic alt_tx
);
  logic serial_val;
  logic picked;

  assign path_bit   = cfg.bitbang ? gpio5 : ser_tx;
  assign serial_val = cfg.mod_en ? (~path_bit & carrier) : path_bit;

  always_comb begin
    unique case (cfg.src)
      SRC_SERIAL: picked = serial_val;
      SRC_VAR:    picked = pulse_var;
      SRC_W:      picked = pulse_w;
      SRC_GPIO:   picked = gpio_tx;
      default:    picked = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opt_tx <= 1'b0;
      alt_tx <= 1'b0;
    end else begin
      opt_tx <= picked ^ cfg.invert;
      alt_tx <= cfg.bitbang ? ser_tx : ser2_tx;
    end
  end
endmodule

// File: rtl/optx_modulator.sv
module optx_modulator
  import optx_pkg::*;
#(
  parameter int unsigned CLK_HZ     = 125_000_000,
  parameter int unsigned CARRIER_HZ = 38_000,
  parameter int unsigned STEPS_LOG2 = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] cfg_src,
  input  logic       cfg_mod_en,
  input  logic [1:0] cfg_duty,
  input  logic       cfg_invert,
  input  logic       cfg_bitbang,
  input  logic       cfg_rx_off,
  input  logic       ser_tx,
  input  logic       ser2_tx,
  input  logic       pulse_var,
  input  logic       pulse_w,
  input  logic       gpio_tx,
  input  logic       gpio5,
  input  logic       opt_rx_pin,
  output logic       opt_tx,
  output logic       alt_tx,
  output logic       opt_rx_data
);
  cfg_t                  cfg_in;
  cfg_t                  cfg_q;
  logic [STEPS_LOG2-1:0] phase;
  logic                  step_tick;
  logic                  frame_end;
  logic                  carrier;
  logic                  path_bit;

  assign cfg_in = '{src: src_e'(cfg_src), mod_en: cfg_mod_en, duty: cfg_duty,
                    invert: cfg_invert, bitbang: cfg_bitbang};

  optx_carrier #(
    .CLK_HZ(CLK_HZ), .CARRIER_HZ(CARRIER_HZ), .STEPS_LOG2(STEPS_LOG2)
  ) u_carrier (
    .clk(clk), .rst_n(rst_n), .duty(cfg_q.duty), .phase(phase),
    .step_tick(step_tick), .frame_end(frame_end), .carrier(carrier)
  );

  optx_cfg_shadow u_shadow (
    .clk(clk), .rst_n(rst_n), .load(frame_end), .cfg_in(cfg_in), .cfg_q(cfg_q)
  );

  optx_route u_route (
    .clk(clk), .rst_n(rst_n), .cfg(cfg_q), .carrier(carrier),
    .ser_tx(ser_tx), .ser2_tx(ser2_tx), .pulse_var(pulse_var), .pulse_w(pulse_w),
    .gpio_tx(gpio_tx), .gpio5(gpio5), .path_bit(path_bit),
    .opt_tx(opt_tx), .alt_tx(alt_tx)
  );

  assign opt_rx_data = cfg_rx_off ? 1'b1 : opt_rx_pin;

endmodule

// File: rtl/optx_modulator_chk.sv
module optx_modulator_chk
  import optx_pkg::*;
#(
  parameter int unsigned STEPS_LOG2 = 5
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [STEPS_LOG2-1:0] phase,
  input logic                  step_tick,
  input logic                  frame_end,
  input logic                  carrier,
  input cfg_t                  cfg_q,
  input logic                  path_bit,
  input logic                  ser_tx,
  input logic                  cfg_rx_off,
  input logic                  opt_tx,
  input logic                  alt_tx,
  input logic                  opt_rx_data
);
  localparam int unsigned HALF = (1 << STEPS_LOG2) / 2;

  p_phase_adv_r6: assert property (@(posedge clk) disable iff (!rst_n)
    step_tick |=> (phase == STEPS_LOG2'($past(phase) + 1'b1)));

  p_phase_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !step_tick |=> $stable(phase));

  p_shadow_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> $stable(cfg_q));

  p_carrier_half_r5: assert property (@(posedge clk) disable iff (!rst_n)
    carrier |-> (int'(phase) < int'(HALF)));

  p_mark_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.mod_en && cfg_q.src == SRC_SERIAL && !cfg_q.invert && path_bit) |=> !opt_tx);

  p_alt_reroute_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q.bitbang |=> (alt_tx == $past(ser_tx)));

  p_rx_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rx_off |-> opt_rx_data);

endmodule

bind optx_modulator optx_modulator_chk #(.STEPS_LOG2(STEPS_LOG2)) u_chk (
  .clk(clk), .rst_n(rst_n), .phase(phase), .step_tick(step_tick),
  .frame_end(frame_end), .carrier(carrier), .cfg_q(cfg_q), .path_bit(path_bit),
  .ser_tx(ser_tx), .cfg_rx_off(cfg_rx_off), .opt_tx(opt_tx), .alt_tx(alt_tx),
  .opt_rx_data(opt_rx_data)
);

// File: tb/optx_modulator_test.sv
`timescale 1ns/1ps
module optx_modulator_test;
  localparam int unsigned CARRIER = 38_000;
  localparam int unsigned DIV     = 3;
  localparam int unsigned CLKHZ   = CARRIER * 32 * DIV;
  localparam int          PER     = 32 * DIV;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] cfg_src = 2'd0, cfg_duty = 2'd0;
  logic cfg_mod_en = 0, cfg_invert = 0, cfg_bitbang = 0, cfg_rx_off = 0;
  logic ser_tx = 0, ser2_tx = 0, pulse_var = 0, pulse_w = 0, gpio_tx = 0, gpio5 = 0;
  logic opt_rx_pin = 0;
  logic opt_tx, alt_tx, opt_rx_data;

  int checks = 0, bad = 0;
  bit done = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  optx_modulator #(.CLK_HZ(CLKHZ), .CARRIER_HZ(CARRIER), .STEPS_LOG2(5)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_src(cfg_src), .cfg_mod_en(cfg_mod_en),
    .cfg_duty(cfg_duty), .cfg_invert(cfg_invert), .cfg_bitbang(cfg_bitbang),
    .cfg_rx_off(cfg_rx_off), .ser_tx(ser_tx), .ser2_tx(ser2_tx),
    .pulse_var(pulse_var), .pulse_w(pulse_w), .gpio_tx(gpio_tx), .gpio5(gpio5),
    .opt_rx_pin(opt_rx_pin), .opt_tx(opt_tx), .alt_tx(alt_tx), .opt_rx_data(opt_rx_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  endtask

  // Behavioural reference: time counted in clocks since reset release.
  int mk;
  int m_src, m_duty;
  bit m_mod, m_inv, m_bb;
  bit exp_tx, exp_alt;
  always @(posedge clk) begin
    int ph, hi;
    bit b, v;
    if (!rst_n) begin
      mk = 0; m_src = 0; m_duty = 0; m_mod = 0; m_inv = 0; m_bb = 0;
      exp_tx = 0; exp_alt = 0;
    end else begin
      ph = (mk / DIV) % 32;
      hi = 16 - 4 * m_duty;
      b  = m_bb ? gpio5 : ser_tx;
      case (m_src)
        0: v = m_mod ? (!b && (ph < hi)) : b;
        1: v = pulse_var;
        2: v = pulse_w;
        default: v = gpio_tx;
      endcase
      exp_tx  = v ^ m_inv;
      exp_alt = m_bb ? ser_tx : ser2_tx;
      if ((mk + 1) % PER == 0) begin
        m_src = cfg_src; m_duty = cfg_duty; m_mod = cfg_mod_en;
        m_inv = cfg_invert; m_bb = cfg_bitbang;
      end
      mk++;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      chk(opt_tx === exp_tx, {cur_req, " opt_tx"}, opt_tx, exp_tx);
      chk(alt_tx === exp_alt, {cur_req, " alt_tx"}, alt_tx, exp_alt);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Settle new settings: two full carrier periods cover the next reload.
  task automatic settle();
    cyc(2 * PER + 2);
  endtask

  task automatic count_high(input int n, output int highs, output int rises);
    bit prev;
    highs = 0; rises = 0; prev = opt_tx;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (opt_tx) highs++;
      if (opt_tx && !prev) rises++;
      prev = opt_tx;
    end
  endtask

  initial begin
    #(8 * 150_000);
    bad++; checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
    finish_run();
  end

  initial begin
    int h, r, n;
    // R1: outputs held low in reset
    cur_req = "R1";
    ser_tx = 1; ser2_tx = 1;
    cyc(4);
    chk(opt_tx === 1'b0, "R1 opt_tx in reset", opt_tx, 0);
    chk(alt_tx === 1'b0, "R1 alt_tx in reset", alt_tx, 0);
    rst_n = 1;
    cyc(1);
    chk(opt_tx === 1'b1, "R1 default source serial", opt_tx, 1);

    // R3: direct serial pass with one clock delay
    cur_req = "R3";
    for (int i = 0; i < 60; i++) begin
      ser_tx = ((i * 7) % 5) > 1; ser2_tx = (i % 3) == 0;
      cyc(1);
    end
    ser_tx = 0; cyc(1);
    chk(opt_tx === 1'b0, "R3 serial zero", opt_tx, 0);

    // R2: each source code
    cur_req = "R2";
    for (int s = 1; s < 4; s++) begin
      cfg_src = 2'(s);
      settle();
      for (int i = 0; i < 40; i++) begin
        pulse_var = (i % 2) == 0; pulse_w = (i % 3) == 0; gpio_tx = (i % 5) < 2;
        ser_tx = (i % 4) == 1;
        cyc(1);
      end
      pulse_var = (s == 1); pulse_w = (s == 2); gpio_tx = (s == 3); ser_tx = 0;
      cyc(1);
      chk(opt_tx === 1'b1, "R2 selected source high", opt_tx, 1);
    end

    // R7: inversion on pulse and serial sources
    cur_req = "R7";
    cfg_invert = 1; cfg_src = 2'd1; pulse_var = 1;
    settle();
    chk(opt_tx === 1'b0, "R7 inverted pulse", opt_tx, 0);
    cfg_src = 2'd0; ser_tx = 0;
    settle();
    chk(opt_tx === 1'b1, "R7 inverted serial", opt_tx, 1);
    cfg_invert = 0;

    // R4: modulation, mark keeps output low
    cur_req = "R4";
    cfg_mod_en = 1; cfg_duty = 2'd0; ser_tx = 1;
    settle();
    count_high(PER, h, r);
    chk(h == 0, "R4 mark gives no carrier", h, 0);

    // R5, R6: duty per code and carrier period
    cur_req = "R5";
    ser_tx = 0;
    for (int d = 0; d < 4; d++) begin
      cfg_duty = 2'(d);
      settle();
      count_high(PER, h, r);
      chk(h == (16 - 4 * d) * DIV, "R5 high clocks per period", h, (16 - 4 * d) * DIV);
    end
    cur_req = "R6";
    count_high(10 * PER, h, r);
    chk(r == 10, "R6 carrier pulses in ten periods", r, 10);

    // R11: pulses unmodulated with modulation enabled
    cur_req = "R11";
    cfg_src = 2'd2; pulse_w = 1;
    settle();
    count_high(PER, h, r);
    chk(h == PER, "R11 steady pulse not modulated", h, PER);

    // R8: bit-bang reroute
    cur_req = "R8";
    cfg_src = 2'd0; cfg_mod_en = 0; cfg_bitbang = 0; ser_tx = 1; ser2_tx = 0; gpio5 = 0;
    settle();
    chk(alt_tx === 1'b0, "R8 alt carries second serial", alt_tx, 0);
    cfg_bitbang = 1;
    settle();
    chk(opt_tx === 1'b0, "R8 opt follows gpio5", opt_tx, 0);
    chk(alt_tx === 1'b1, "R8 alt carries serial", alt_tx, 1);
    for (int i = 0; i < 30; i++) begin
      gpio5 = (i % 3) == 1; ser_tx = (i % 2) == 0; ser2_tx = (i % 5) == 0;
      cyc(1);
    end
    cfg_bitbang = 0;

    // R10: mid-period change waits for the wrap
    cur_req = "R10";
    cfg_src = 2'd3; gpio_tx = 0; cfg_invert = 0;
    settle();
    while (mk % PER != 5) @(negedge clk);
    cfg_invert = 1;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!opt_tx && n < 200);
    chk(n == PER - 4, "R10 first clock showing new setting", n, PER - 4);

    // R9: receive disable
    cur_req = "R9";
    cfg_rx_off = 0; opt_rx_pin = 0; #1;
    chk(opt_rx_data === 1'b0, "R9 rx follows pin low", opt_rx_data, 0);
    opt_rx_pin = 1; #1;
    chk(opt_rx_data === 1'b1, "R9 rx follows pin high", opt_rx_data, 1);
    cfg_rx_off = 1; opt_rx_pin = 0; #1;
    chk(opt_rx_data === 1'b1, "R9 rx parked idle", opt_rx_data, 1);
    cyc(3);
    finish_run();
  end
endmodule